// File: doc/BRIEF.md
# Prescaled Up/Down Basic Timer

A general-purpose timer in the system clock domain. A prescaler divides the clock by a programmable ratio, and the resulting tick steps a counter either up or down. When the counter reaches its terminal value it raises an event. The event sets a sticky status flag and, if enabled, an interrupt line. After the event the counter either restarts automatically or stops and clears its own start bit.

Software reaches the timer through five 32-bit registers on a simple write-strobe bus with a combinational read. The registers are count, preload, status, interrupt enable and control. Control also carries three actions that clear themselves: a soft reset that restores every register, a reload that copies preload into count, and a halt that freezes the timer without losing its state.

A common setup counts up with auto-restart and a preload of all ones. The counter then runs freely as a timebase. Software can poll it and measure elapsed time by unsigned subtraction, which stays correct when the count wraps.

Top module: `basic_tmr`

## Requirements
- R1: After the reset input, all five registers read 0 and `irq` is low.
- R2: The byte addresses are count 0x00, preload 0x04, status 0x08, interrupt enable 0x0C and control 0x10. Count, preload, interrupt-enable bit 0 and the control fields read back what was last written. Reserved control bits (1 and 15:8) read 0.
- R3: Control bits 31:16 hold a divider value P. While running, the count changes once every P+1 clocks. The timer runs when bit 0 (active) and bit 5 (start) are 1 and bit 7 (halt) is 0. The first step comes P+1 clocks after the edge that writes control.
- R4: With control bit 2 at 0, the count decrements on each tick. A tick that finds the count at 0 is the event. If bit 3 (auto-restart) is 1, that tick loads preload into count.
- R5: With control bit 2 at 1, the count increments on each tick. A tick that finds the count equal to preload is the event. With auto-restart that tick loads 0. With preload 0xFFFFFFFF the count wraps from all ones to 0.
- R6: When auto-restart is 0, the event clears the start bit (bit 5). The count stays at its terminal value and no further ticks occur.
- R7: Status bit 0 is set by the event and cleared by writing 1 to it. An event in the same cycle as the clear wins.
- R8: `irq` is high exactly when status bit 0 and interrupt-enable bit 0 are both 1.
- R9: Writing control with bit 6 set copies preload into count at that clock edge. Bit 6 reads back 0.
- R10: While halt (bit 7) is 1, both the prescaler phase and the count hold. After halt is cleared, counting resumes from the held prescaler phase.
- R11: Writing control with bit 4 set returns every register to its reset value at that edge, including the prescaler phase. Bit 4 reads back 0.
- R12: With active (bit 0) at 0, the count does not change and the prescaler phase is cleared, even if start is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe for one clock |
| bus_addr | input | 5 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Interrupt request |

## Verification
The bench goes after several corner cases, each with a distinct failure:
- Terminal tick in both directions. A design that fires one tick early or late returns a count off by one after reload.
- Full 32-bit wrap in up mode. A design that compares against the wrong terminal value stops at all ones.
- Single-shot stop. A design that keeps counting moves past 0 or past preload instead of stopping.
- Halt. It lands in the middle of a prescaler period. A design that resets the prescaler on halt delays the next step by a whole period, and the bench sees it.
- Reload and soft-reset strobes. The bench reads these back through control. A design that latches them shows nonzero bits there, and a design that misses the reload shows a stale count.

// File: rtl/btmr_pkg.sv
package btmr_pkg;

    localparam int BUS_AW = 5;
    localparam int BUS_DW = 32;
    localparam int DIV_W  = 16;

    localparam logic [BUS_AW-1:0] ADR_COUNT   = 5'h00;
    localparam logic [BUS_AW-1:0] ADR_PRELOAD = 5'h04;
    localparam logic [BUS_AW-1:0] ADR_STATUS  = 5'h08;
    localparam logic [BUS_AW-1:0] ADR_IRQEN   = 5'h0C;
    localparam logic [BUS_AW-1:0] ADR_CTRL    = 5'h10;

    localparam int BIT_SRST   = 4;
    localparam int BIT_RELOAD = 6;

    typedef struct packed {
        logic [DIV_W-1:0] div;
        logic [7:0]       rsv_hi;
        logic             halt;
        logic             reload;
        logic             start;
        logic             srst;
        logic             autorun;
        logic             up;
        logic             rsv_lo;
        logic             active;
    } ctrl_t;

    typedef enum logic [1:0] {
        PS_IDLE,
        PS_HOLD,
        PS_RUN
    } ps_mode_e;

    function automatic ctrl_t ctrl_from_bus(input logic [BUS_DW-1:0] d);
        ctrl_t c;
        c        = ctrl_t'(d);
        c.rsv_hi = '0;
        c.rsv_lo = 1'b0;
        c.srst   = 1'b0;
        c.reload = 1'b0;
        return c;
    endfunction

    function automatic ps_mode_e ps_mode(input ctrl_t c);
        if (!(c.active && c.start)) return PS_IDLE;
        if (c.halt)                 return PS_HOLD;
        return PS_RUN;
    endfunction

endpackage

// File: rtl/btmr_regs.sv
module btmr_regs
    import btmr_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic                  clk,
    input  logic                  clr,
    input  logic                  wr,
    input  logic [BUS_AW-1:0]     addr,
    input  logic [BUS_DW-1:0]     wdata,
    input  logic                  evt,
    output ctrl_t                 ctrl,
    output logic [CNT_W-1:0]      preload,
    output logic                  status,
    output logic                  irq_en
);

    logic wr_pre, wr_ien, wr_ctl, wr_sts;

    always_comb begin
        wr_pre = wr && (addr == ADR_PRELOAD);
        wr_ien = wr && (addr == ADR_IRQEN);
        wr_ctl = wr && (addr == ADR_CTRL);
        wr_sts = wr && (addr == ADR_STATUS);
    end

    always_ff @(posedge clk) begin
        if (clr) begin
            ctrl    <= ctrl_t'('0);
            preload <= '0;
            status  <= 1'b0;
            irq_en  <= 1'b0;
        end else begin
            if (wr_pre) preload <= wdata[CNT_W-1:0];
            if (wr_ien) irq_en  <= wdata[0];

            if (wr_ctl)
                ctrl <= ctrl_from_bus(wdata);
            else if (evt && !ctrl.autorun)
                ctrl.start <= 1'b0;

            if (evt)
                status <= 1'b1;
            else if (wr_sts && wdata[0])
                status <= 1'b0;
        end
    end

endmodule

// File: rtl/btmr_prescale.sv
module btmr_prescale
    import btmr_pkg::*;
(
    input  logic             clk,
    input  logic             clr,
    input  ctrl_t            ctrl,
    output logic             tick
);

    ps_mode_e         mode;
    logic [DIV_W-1:0] phase;

    always_comb begin
        mode = ps_mode(ctrl);
        tick = (mode == PS_RUN) && (phase >= ctrl.div);
    end

    always_ff @(posedge clk) begin
        if (clr) begin
            phase <= '0;
        end else begin
            unique case (mode)
                PS_IDLE: phase <= '0;
                PS_HOLD: phase <= phase;
                default: phase <= tick ? '0 : phase + 1'b1;
            endcase
        end
    end

endmodule

// File: rtl/btmr_counter.sv
module btmr_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             clr,
    input  logic             tick,
    input  logic             up,
    input  logic             autorun,
    input  logic [CNT_W-1:0] preload,
    input  logic             wr_cnt,
    input  logic             load,
    input  logic [CNT_W-1:0] wdata,
    output logic [CNT_W-1:0] count,
    output logic             evt
);

    logic             at_end;
    logic [CNT_W-1:0] restart_val;
    logic [CNT_W-1:0] step_val;

    always_comb begin
        at_end      = up ? (count == preload) : (count == '0);
        evt         = tick && at_end;
        restart_val = up ? '0 : preload;
        step_val    = up ? count + 1'b1 : count - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (clr)
            count <= '0;
        else if (wr_cnt)
            count <= wdata;
        else if (load)
            count <= preload;
        else if (evt) begin
            if (autorun) count <= restart_val;
        end else if (tick)
            count <= step_val;
    end

endmodule

// File: rtl/basic_tmr.sv
module basic_tmr
    import btmr_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [4:0]        bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              irq
);

    ctrl_t            ctrl_q;
    logic [CNT_W-1:0] preload_q;
    logic [CNT_W-1:0] count_q;
    logic             status_q;
    logic             irq_en_q;
    logic             evt;
    logic             tick;
    logic             soft_rst;
    logic             clr_all;
    logic             wr_cnt;
    logic             do_load;

    always_comb begin
        soft_rst = bus_wr && (bus_addr == ADR_CTRL) && bus_wdata[BIT_SRST];
        clr_all  = rst || soft_rst;
        wr_cnt   = bus_wr && (bus_addr == ADR_COUNT);
        do_load  = bus_wr && (bus_addr == ADR_CTRL) && bus_wdata[BIT_RELOAD];
    end

    btmr_regs #(.CNT_W(CNT_W)) u_regs (
        .clk     (clk),
        .clr     (clr_all),
        .wr      (bus_wr),
        .addr    (bus_addr),
        .wdata   (bus_wdata),
        .evt     (evt),
        .ctrl    (ctrl_q),
        .preload (preload_q),
        .status  (status_q),
        .irq_en  (irq_en_q)
    );

    btmr_prescale u_psc (
        .clk  (clk),
        .clr  (clr_all),
        .ctrl (ctrl_q),
        .tick (tick)
    );

    btmr_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .clr     (clr_all),
        .tick    (tick),
        .up      (ctrl_q.up),
        .autorun (ctrl_q.autorun),
        .preload (preload_q),
        .wr_cnt  (wr_cnt),
        .load    (do_load),
        .wdata   (bus_wdata[CNT_W-1:0]),
        .count   (count_q),
        .evt     (evt)
    );

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            ADR_COUNT:   bus_rdata[CNT_W-1:0] = count_q;
            ADR_PRELOAD: bus_rdata[CNT_W-1:0] = preload_q;
            ADR_STATUS:  bus_rdata[0]         = status_q;
            ADR_IRQEN:   bus_rdata[0]         = irq_en_q;
            ADR_CTRL:    bus_rdata            = ctrl_q;
            default:     bus_rdata            = '0;
        endcase
    end

    assign irq = status_q && irq_en_q;

endmodule

// File: rtl/btmr_chk.sv
module btmr_chk
    import btmr_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             bus_wr,
    input logic [4:0]       bus_addr,
    input logic [31:0]      bus_wdata,
    input logic [CNT_W-1:0] count_q,
    input logic [CNT_W-1:0] preload_q,
    input ctrl_t            ctrl_q,
    input logic             status_q,
    input logic             irq_en_q,
    input logic             evt
);

    logic ctl_wr;
    assign ctl_wr = bus_wr && (bus_addr == ADR_CTRL);

    AST_EVT_SETS_STATUS: assert property (@(posedge clk) disable iff (rst)
        (evt && !(ctl_wr && bus_wdata[BIT_SRST])) |=> status_q); // R7

    AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q.halt && !bus_wr) |=> $stable(count_q)); // R10

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!ctrl_q.active && !bus_wr) |=> $stable(count_q)); // R12

    AST_SRST_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (ctl_wr && bus_wdata[BIT_SRST]) |=>
        (count_q == '0 && preload_q == '0 && ctrl_q == ctrl_t'('0) && !status_q && !irq_en_q)); // R11

    AST_RELOAD_COPIES: assert property (@(posedge clk) disable iff (rst)
        (ctl_wr && bus_wdata[BIT_RELOAD] && !bus_wdata[BIT_SRST]) |=>
        (count_q == $past(preload_q))); // R9

    AST_ONESHOT_STOPS: assert property (@(posedge clk) disable iff (rst)
        (evt && !ctrl_q.autorun && !ctl_wr) |=> !ctrl_q.start); // R6

endmodule

bind basic_tmr btmr_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .count_q   (count_q),
    .preload_q (preload_q),
    .ctrl_q    (ctrl_q),
    .status_q  (status_q),
    .irq_en_q  (irq_en_q),
    .evt       (evt)
);

// File: tb/tb_basic_tmr.sv
`timescale 1ns/1ps
module tb_basic_tmr;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    localparam logic [4:0] A_CNT = 5'h00, A_PRE = 5'h04, A_STS = 5'h08, A_IEN = 5'h0C, A_CTL = 5'h10;

    always #2.5 clk = ~clk;

    basic_tmr dut (
        .clk       (clk),
        .rst       (rst),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    typedef struct packed {
        logic [15:0] psc;
        logic        up;
        logic        ar;
        logic [31:0] pre;
        logic [31:0] cnt0;
        logic [7:0]  n;
        logic [31:0] exp_cnt;
        logic        exp_st;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{16'd0, 1'b0, 1'b1, 32'd5,          32'd5,          8'd3,  32'd2, 1'b0},
        '{16'd0, 1'b0, 1'b1, 32'd3,          32'd3,          8'd4,  32'd3, 1'b1},
        '{16'd2, 1'b0, 1'b1, 32'd10,         32'd10,         8'd9,  32'd7, 1'b0},
        '{16'd0, 1'b1, 1'b1, 32'd4,          32'd0,          8'd3,  32'd3, 1'b0},
        '{16'd0, 1'b1, 1'b1, 32'd4,          32'd0,          8'd5,  32'd0, 1'b1},
        '{16'd0, 1'b1, 1'b1, 32'hFFFF_FFFF,  32'hFFFF_FFFE,  8'd3,  32'd1, 1'b1},
        '{16'd0, 1'b0, 1'b0, 32'd7,          32'd2,          8'd5,  32'd0, 1'b1},
        '{16'd1, 1'b1, 1'b0, 32'd3,          32'd0,          8'd12, 32'd3, 1'b1},
        '{16'd3, 1'b0, 1'b1, 32'd2,          32'd2,          8'd13, 32'd2, 1'b1}
    };

    function automatic logic [31:0] ctl_word(input logic [15:0] psc, input logic up,
                                             input logic ar, input logic halt);
        return {psc, 8'h00, halt, 1'b0, 1'b1, 1'b0, ar, up, 1'b0, 1'b1};
    endfunction

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        end
    endtask

    initial begin
        #(200000 * 5);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        summary();
        $finish;
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(A_CNT, d); chk("R1 count", d, 0);
        rd(A_PRE, d); chk("R1 preload", d, 0);
        rd(A_STS, d); chk("R1 status", d, 0);
        rd(A_IEN, d); chk("R1 irq_en", d, 0);
        rd(A_CTL, d); chk("R1 control", d, 0);
        chk("R1 irq", {31'd0, irq}, 0);

        // R2 readback, reserved control bits read 0
        wr(A_PRE, 32'hA5A5_1234); rd(A_PRE, d); chk("R2 preload", d, 32'hA5A5_1234);
        wr(A_CTL, 32'h0003_FF8E); rd(A_CTL, d); chk("R2 control", d, 32'h0003_008C);

        // table of vectors: R3 R4 R5 R7 R8
        for (int i = 0; i < NV; i++) begin
            wr(A_CTL, 32'h10);
            wr(A_PRE, VECS[i].pre);
            wr(A_CNT, VECS[i].cnt0);
            wr(A_IEN, 32'd1);
            wr(A_CTL, ctl_word(VECS[i].psc, VECS[i].up, VECS[i].ar, 1'b0));
            repeat (int'(VECS[i].n)) @(negedge clk);
            rd(A_CNT, d); chk($sformatf("R3 R4 R5 R6 count vec%0d", i), d, VECS[i].exp_cnt);
            rd(A_STS, d); chk($sformatf("R7 status vec%0d", i), d, {31'd0, VECS[i].exp_st});
            chk($sformatf("R8 irq vec%0d", i), {31'd0, irq}, {31'd0, VECS[i].exp_st});
        end

        // R6 single shot, R8 masking, R7 clear
        wr(A_CTL, 32'h10);
        wr(A_CTL, ctl_word(16'd0, 1'b0, 1'b0, 1'b0));
        repeat (2) @(negedge clk);
        rd(A_CTL, d); chk("R6 start cleared", d, 32'h1);
        rd(A_STS, d); chk("R7 event sets status", d, 1);
        chk("R8 irq masked", {31'd0, irq}, 0);
        wr(A_IEN, 32'd1);
        chk("R8 irq enabled", {31'd0, irq}, 1);
        wr(A_STS, 32'd1);
        rd(A_STS, d); chk("R7 write one clears", d, 0);
        chk("R8 irq after clear", {31'd0, irq}, 0);

        // R12 inactive
        wr(A_CTL, 32'h10);
        wr(A_CNT, 32'd9);
        wr(A_CTL, 32'h0000_0028);
        repeat (5) @(negedge clk);
        rd(A_CNT, d); chk("R12 inactive hold", d, 9);

        // R10 halt keeps prescaler phase
        wr(A_CTL, 32'h10);
        wr(A_PRE, 32'd100);
        wr(A_CNT, 32'd100);
        wr(A_CTL, ctl_word(16'd3, 1'b0, 1'b1, 1'b0));
        wr(A_CTL, ctl_word(16'd3, 1'b0, 1'b1, 1'b1));
        repeat (6) @(negedge clk);
        rd(A_CNT, d); chk("R10 halted count", d, 100);
        wr(A_CTL, ctl_word(16'd3, 1'b0, 1'b1, 1'b0));
        @(negedge clk);
        rd(A_CNT, d); chk("R10 resume early", d, 100);
        @(negedge clk);
        rd(A_CNT, d); chk("R10 resume phase kept", d, 99);

        // R9 reload
        wr(A_CTL, 32'h10);
        wr(A_PRE, 32'd20);
        wr(A_CNT, 32'd20);
        wr(A_CTL, ctl_word(16'd0, 1'b0, 1'b1, 1'b0));
        wr(A_PRE, 32'd50);
        wr(A_CTL, ctl_word(16'd0, 1'b0, 1'b1, 1'b0) | 32'h40);
        rd(A_CNT, d); chk("R9 reload copies", d, 50);
        rd(A_CTL, d); chk("R9 reload self-clears", d, ctl_word(16'd0, 1'b0, 1'b1, 1'b0));

        // R11 soft reset
        wr(A_IEN, 32'd1);
        wr(A_CTL, 32'h10);
        rd(A_CNT, d); chk("R11 count", d, 0);
        rd(A_PRE, d); chk("R11 preload", d, 0);
        rd(A_STS, d); chk("R11 status", d, 0);
        rd(A_IEN, d); chk("R11 irq_en", d, 0);
        rd(A_CTL, d); chk("R11 control", d, 0);

        summary();
        $finish;
    end

endmodule